// File: doc/BRIEF.md
# Mixed-Trigger Masked Interrupt Controller

This block gathers 22 interrupt request lines into one request for a processor. Sources 1 to 15 are level-sensitive. Their pending bits follow the input directly. Sources 16 to 22 are edge-detected. A chosen edge sets a sticky pending bit, which stays set until software clears it. Each source has its own enable mask and its own priority bit.

The output request is gated by a global enable. Disabling the global enable records the state it replaced, so software can read that state back and restore it later.

When high- and low-priority sources are active together, only the high-priority class is presented. The low-priority requests are held off until no unmasked high-priority source is pending. Software uses a small register port. A write takes effect at the clock edge, and a read returns data combinationally from `addr_i`.

Source n maps to bit n-1 of every source-wide register: bits 0..14 are the level sources and bits 15..21 are the edge sources.

Register map (4-bit address):
- 0: mask (read/write, 1 = enabled)
- 1: mask bit clear (writing 1 clears that mask bit; reads the mask)
- 2: priority (read/write, 1 = high)
- 3: edge polarity (bits 15..21; 1 = falling)
- 4: pending (read; writing 1 clears that edge bit)
- 5: clear all pending (write)
- 6: global enable (bit 0)
- 7: global disable (a write clears the enable; a read returns the captured state in bit 0)
- 8: selected sources (read)

Top module: `mixed_irq_ctrl`

## Requirements
- R1: Pending bits 0..14 equal the live value of `src_i[14:0]` at all times. A clear write at address 4 or address 5 does not change them.
- R2: Each edge source (bits 15..21) sets its pending bit at the first clock edge after its input makes the transition chosen by its polarity bit at address 3. A polarity bit of 0 selects a rising (0 to 1) transition and a polarity bit of 1 selects a falling transition. The opposite transition sets nothing.
- R3: An edge pending bit stays set until it is cleared. It is cleared by writing 1 to its bit at address 4, or by any write to address 5. A 0 written at address 4 leaves its bit unchanged.
- R4: If a selected edge and a clear of the same bit land on the same clock edge, the pending bit ends up set.
- R5: The mask at address 0 reads back the value written. A write to address 1 clears exactly those mask bits that are written as 1.
- R6: A write to address 7 clears the global enable and captures its previous value, which then reads back in bit 0 of address 7. A write to address 6 loads the enable from data bit 0, which is how a saved state is restored.
- R7: `irq_o` is 1 exactly when the global enable is 1 and the selected vector at address 8 is nonzero.
- R8: The selected vector is pending AND mask AND priority when that result is nonzero, and pending AND mask otherwise. `irq_hi_o` is 1 exactly in the first case.
- R9: After reset, mask, priority, polarity, edge pending, global enable and captured enable are all 0, and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 22 | Request lines, bit n-1 = source n, synchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address for write and read |
| wdata_i | input | 22 | Write data |
| rdata_o | output | 22 | Read data for addr_i |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_hi_o | output | 1 | Presented request belongs to the high-priority class |

## Verification
The bench sweeps every level source and tries to clear it while it is held high. A design that latched level sources would keep a stale bit after the input dropped, and one that obeyed the clear would lose a live request.

Every edge source is swept under both polarities, and the transition of the wrong polarity is checked to set nothing. A design that compared against the wrong sample or ignored polarity would raise spurious or missed pending bits.

An edge is made to coincide with its own clear, which catches a clear that wins. Nested global disables are run to catch a captured state that was overwritten wrongly.

A priority sweep pairs every level source with another source. This exposes a design that mixes the two classes or that blocks low-priority requests when no high-priority source is actually unmasked.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_MASK     = 4'd0,
    A_MASK_CLR = 4'd1,
    A_PRIO     = 4'd2,
    A_POL      = 4'd3,
    A_PEND     = 4'd4,
    A_CLR_ALL  = 4'd5,
    A_GEN      = 4'd6,
    A_GDIS     = 4'd7,
    A_SEL      = 4'd8
  } irq_addr_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] fall_i,
  output logic [N-1:0] hit_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= src_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_det
    assign hit_o[i] = fall_i[i] ? (prev_q[i] & ~src_i[i]) : (src_i[i] & ~prev_q[i]);
  end
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int N_SRC = 22,
  parameter int N_LVL = 15,
  localparam int N_EDGE = N_SRC - N_LVL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_LVL-1:0]  lvl_i,
  input  logic [N_EDGE-1:0] hit_i,
  input  logic [N_EDGE-1:0] clr_i,
  output logic [N_SRC-1:0]  pend_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    if (i < N_LVL) begin : g_lvl
      assign pend_o[i] = lvl_i[i];
    end else begin : g_edge
      logic q;
      // a new edge overrides a clear on the same cycle
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= hit_i[i-N_LVL] | (q & ~clr_i[i-N_LVL]);
      end
      assign pend_o[i] = q;
    end
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int N = 22
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] prio_i,
  input  logic         en_i,
  output logic [N-1:0] sel_o,
  output logic         irq_o,
  output logic         hi_o
);
  logic [N-1:0] act, act_hi;

  always_comb begin
    act    = pend_i & mask_i;
    act_hi = act & prio_i;
    hi_o   = |act_hi;
    sel_o  = hi_o ? act_hi : act;
    irq_o  = en_i & (|sel_o);
  end
endmodule

// File: rtl/mixed_irq_ctrl.sv
module mixed_irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC = 22,
  parameter int N_LVL = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  rdata_o,
  output logic              irq_o,
  output logic              irq_hi_o
);
  localparam int N_EDGE = N_SRC - N_LVL;

  logic [N_SRC-1:0]  mask_q, prio_q, pend, sel;
  logic [N_EDGE-1:0] pol_q, hit, clr_edge;
  logic              en_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      prio_q <= '0;
      pol_q  <= '0;
      en_q   <= 1'b0;
      prev_q <= 1'b0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_MASK:     mask_q <= wdata_i;
        A_MASK_CLR: mask_q <= mask_q & ~wdata_i;
        A_PRIO:     prio_q <= wdata_i;
        A_POL:      pol_q  <= wdata_i[N_SRC-1:N_LVL];
        A_GEN:      en_q   <= wdata_i[0];
        A_GDIS: begin
          prev_q <= en_q;
          en_q   <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    clr_edge = '0;
    if (wr_en_i && addr_i == A_PEND)    clr_edge = wdata_i[N_SRC-1:N_LVL];
    if (wr_en_i && addr_i == A_CLR_ALL) clr_edge = '1;
  end

  irq_edge_det #(.N(N_EDGE)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i[N_SRC-1:N_LVL]),
    .fall_i (pol_q),
    .hit_o  (hit)
  );

  irq_pend #(.N_SRC(N_SRC), .N_LVL(N_LVL)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (src_i[N_LVL-1:0]),
    .hit_i  (hit),
    .clr_i  (clr_edge),
    .pend_o (pend)
  );

  irq_arb #(.N(N_SRC)) u_arb (
    .pend_i (pend),
    .mask_i (mask_q),
    .prio_i (prio_q),
    .en_i   (en_q),
    .sel_o  (sel),
    .irq_o  (irq_o),
    .hi_o   (irq_hi_o)
  );

  always_comb begin
    case (addr_i)
      A_MASK, A_MASK_CLR: rdata_o = mask_q;
      A_PRIO:             rdata_o = prio_q;
      A_POL:              rdata_o = {pol_q, {N_LVL{1'b0}}};
      A_PEND:             rdata_o = pend;
      A_GEN:              rdata_o = N_SRC'(en_q);
      A_GDIS:             rdata_o = N_SRC'(prev_q);
      A_SEL:              rdata_o = sel;
      default:            rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mixed_irq_ctrl_chk.sv
module mixed_irq_ctrl_chk
  import irq_pkg::*;
#(
  parameter int N_SRC = 22,
  parameter int N_LVL = 15,
  localparam int N_EDGE = N_SRC - N_LVL
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  src_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_SRC-1:0]  pend,
  input logic [N_SRC-1:0]  mask_q,
  input logic [N_SRC-1:0]  prio_q,
  input logic [N_EDGE-1:0] hit,
  input logic [N_EDGE-1:0] clr_edge,
  input logic              en_q,
  input logic              prev_q,
  input logic              irq_o,
  input logic              irq_hi_o
);
  // R1
  a_r1_level_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend[N_LVL-1:0] == src_i[N_LVL-1:0]);

  // R3
  a_r3_edge_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(pend[N_SRC-1:N_LVL]) & ~$past(clr_edge)) & ~pend[N_SRC-1:N_LVL]) == '0));

  // R2 and R4: a detected edge always leaves its bit set
  a_r4_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(hit) & ~pend[N_SRC-1:N_LVL]) == '0));

  // R6
  a_r6_disable_saves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_GDIS) |=> (!en_q && prev_q == $past(en_q)));

  // R7
  a_r7_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_q && (|(pend & mask_q))));

  // R8
  a_r8_high_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend & mask_q & prio_q)) |-> irq_hi_o);

  a_r8_hi_needs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hi_o |-> (|(pend & mask_q & prio_q)));
endmodule

bind mixed_irq_ctrl mixed_irq_ctrl_chk #(.N_SRC(N_SRC), .N_LVL(N_LVL)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .src_i    (src_i),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .pend     (pend),
  .mask_q   (mask_q),
  .prio_q   (prio_q),
  .hit      (hit),
  .clr_edge (clr_edge),
  .en_q     (en_q),
  .prev_q   (prev_q),
  .irq_o    (irq_o),
  .irq_hi_o (irq_hi_o)
);

// File: tb/mixed_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mixed_irq_ctrl_tb_top;
  localparam int NS = 22;
  localparam int NL = 15;
  localparam logic [NS-1:0] EDGE_M = 22'h3F8000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          wr_en = 1'b0;
  logic [3:0]    addr = '0;
  logic [NS-1:0] wdata = '0;
  logic [NS-1:0] rdata;
  logic          irq, irq_hi;
  int            total = 0, bad = 0;
  bit            done = 1'b0;
  logic [NS-1:0] v;

  always #5 clk = ~clk;

  mixed_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .irq_hi_o(irq_hi)
  );

  task automatic chk(input string tag, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [NS-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [NS-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    for (int a = 0; a <= 8; a++) begin
      rd(4'(a), v);
      chk("R9 reset reg", v, '0);
    end
    chk("R9 irq reset", {21'b0, irq}, '0);

    // R1 level sources live, not clearable
    for (int i = 0; i < NL; i++) begin
      @(negedge clk) src[i] = 1'b1;
      wr(4'd4, '1);
      wr(4'd5, '0);
      rd(4'd4, v);
      chk("R1 level held", v, NS'(1) << i);
      @(negedge clk) src[i] = 1'b0;
      rd(4'd4, v);
      chk("R1 level drop", v, '0);
    end

    // R2/R3 rising edges, per-source clear
    for (int i = NL; i < NS; i++) begin
      @(negedge clk) src[i] = 1'b1;
      @(negedge clk) src[i] = 1'b0;
      rd(4'd4, v);
      chk("R2 rise sets", v, NS'(1) << i);
      wr(4'd4, ~(NS'(1) << i));
      rd(4'd4, v);
      chk("R3 zero clear keeps", v, NS'(1) << i);
      wr(4'd4, NS'(1) << i);
      rd(4'd4, v);
      chk("R3 clear one", v, '0);
    end

    // R2 falling polarity
    wr(4'd3, '1);
    rd(4'd3, v);
    chk("R2 pol readback", v, EDGE_M);
    for (int i = NL; i < NS; i++) begin
      @(negedge clk) src[i] = 1'b1;
      rd(4'd4, v);
      chk("R2 rise ignored", v, '0);
      @(negedge clk) src[i] = 1'b0;
      rd(4'd4, v);
      chk("R2 fall sets", v, NS'(1) << i);
      wr(4'd4, NS'(1) << i);
    end
    wr(4'd3, '0);

    // R3 clear-all with a level source held
    @(negedge clk) src = EDGE_M | 22'h8;
    @(negedge clk) src = 22'h8;
    rd(4'd4, v);
    chk("R3 all edges", v, EDGE_M | 22'h8);
    wr(4'd5, '0);
    rd(4'd4, v);
    chk("R3 clear all", v, 22'h8);
    @(negedge clk) src = '0;

    // R4 edge coincides with clear
    @(negedge clk) src[16] = 1'b1;
    @(negedge clk) src[16] = 1'b0;
    @(negedge clk);
    src[16] = 1'b1; wr_en = 1'b1; addr = 4'd4; wdata = NS'(1) << 16;
    @(negedge clk);
    wr_en = 1'b0; src[16] = 1'b0;
    rd(4'd4, v);
    chk("R4 edge wins", v, NS'(1) << 16);
    wr(4'd5, '0);

    // R5 mask write and bit clear
    wr(4'd0, 22'h2AAAAA);
    rd(4'd0, v);
    chk("R5 mask rw", v, 22'h2AAAAA);
    wr(4'd1, 22'h00F00F);
    rd(4'd1, v);
    chk("R5 mask bit clear", v, 22'h2AAAAA & ~22'h00F00F);
    @(negedge clk) src = 22'h7FFF;
    rd(4'd8, v);
    chk("R5 masked sel", v, 22'h7FFF & 22'h2AAAAA & ~22'h00F00F);

    // R6/R7 global enable, nested disable, restore
    wr(4'd0, '1);
    @(negedge clk) src = 22'h1;
    #1 chk("R7 off no irq", {21'b0, irq}, '0);
    wr(4'd6, 22'h1);
    #1 chk("R7 on irq", {21'b0, irq}, 22'h1);
    wr(4'd7, '0);
    #1 chk("R6 disable irq", {21'b0, irq}, '0);
    rd(4'd7, v);
    chk("R6 saved 1", v, 22'h1);
    wr(4'd7, '0);
    rd(4'd7, v);
    chk("R6 saved 0", v, '0);
    wr(4'd6, 22'h1);
    #1 chk("R6 restore irq", {21'b0, irq}, 22'h1);
    @(negedge clk) src = '0;
    #1 chk("R7 none pending", {21'b0, irq}, '0);

    // R8 priority sweep over level pairs
    for (int i = 0; i < NL; i++) begin
      int j = (i + 5) % NL;
      wr(4'd2, NS'(1) << i);
      @(negedge clk) src = (NS'(1) << i) | (NS'(1) << j);
      rd(4'd8, v);
      chk("R8 high only", v, NS'(1) << i);
      chk("R8 hi flag", {21'b0, irq_hi}, 22'h1);
      wr(4'd2, NS'(1) << ((i + 1) % NL == j ? (i + 2) % NL : (i + 1) % NL));
      rd(4'd8, v);
      chk("R8 low when no high", v, (NS'(1) << i) | (NS'(1) << j));
      chk("R8 hi flag low", {21'b0, irq_hi}, '0);
      chk("R7 irq low class", {21'b0, irq}, 22'h1);
    end
    // high source pending but masked does not block
    wr(4'd2, 22'h1);
    wr(4'd1, 22'h1);
    @(negedge clk) src = 22'h3;
    rd(4'd8, v);
    chk("R8 masked high", v, 22'h2);

    summary();
  end
endmodule